// File: doc/BRIEF.md
# SHA-1 Message Schedule Generator

This block turns one 512-bit message block into the eighty 32-bit round words that a SHA-1 compression round consumes, delivering one word per enabled clock cycle together with its round index. It keeps only a sixteen-word sliding window instead of all eighty words. The first sixteen words are the message words themselves. Every later word is built from four earlier words in the window, and the result is written back into the window so that the recurrence can keep running.

A start pulse captures the block and resets the round index. A round unit downstream takes the presented word on each rising edge where `wt_valid` is high. Dropping `enable` stalls the schedule with no loss of state. After word 79 has been taken the block goes idle until the next start. The round logic itself lies outside this block.

Top module: `sha1_wsched`

## Requirements
- R1: While reset is active and after it is released, with no start yet, `wt_valid` is 0 and `wt_idx` is 0.
- R2: A start sampled at a rising edge loads `block_in`. From the next cycle the index is 0 and the word is block word 0. Block word k is `block_in[511-32k -: 32]`, so word 0 is the most significant 32 bits.
- R3: For round index t from 0 to 15, the presented word equals block word t.
- R4: For t from 16 to 79, the presented word equals the XOR of the words at rounds t-3, t-8, t-14 and t-16, rotated left by one bit.
- R5: Each rising edge where `wt_valid` is 1 and start is 0 advances the index by exactly one. Over a full run, indices 0 to 79 appear in order with none skipped or repeated.
- R6: While a run is in progress and `enable` is 0, `wt_valid` is 0, and `wt_idx` and `wt_word` keep showing the word that is still pending. That word is then presented unchanged when `enable` returns.
- R7: Once word 79 has been taken, `wt_valid` stays 0 and `wt_idx` returns to 0, even with `enable` held high, until the next start.
- R8: A start in the middle of a run takes priority over advancing. The next cycle presents index 0 and word 0 of the new block, and the following eighty words are those of the new block.
- R9: A start with `enable` low still loads the block. `wt_valid` stays 0 until `enable` rises, and word 0 is then presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `block_in` and restart at round 0 |
| enable | input | 1 | Allow the current word to be taken and the schedule to advance |
| block_in | input | 512 | Message block; word 0 is bits 511:480 |
| wt_word | output | 32 | Round word for index `wt_idx` |
| wt_idx | output | 7 | Round index t of the presented word |
| wt_valid | output | 1 | Presented word is valid and is taken at the next rising edge |

## Verification
A wrong tap position, a wrong rotate amount or a shift that skips a cycle does not show during the first sixteen rounds. It appears as a wrong word at round 16 at the earliest. Because each computed word feeds later ones, the error then spreads to most of the remaining rounds of the same block. Errors in the index counter or the stall logic show at once as a repeated or skipped `wt_idx`, a valid level that does not follow `enable`, or a word that changes during a stall. These are checked on every cycle of runs with random stalls, restarts in the middle of a run, and both constant and random blocks.

// File: rtl/sha1_ws_pkg.sv
`timescale 1ns/1ps
package sha1_ws_pkg;

   localparam int unsigned DEF_WORD_W = 32;
   localparam int unsigned DEF_WINDOW = 16;
   localparam int unsigned DEF_ROUNDS = 80;
   localparam int unsigned DEF_ROT    = 1;
   localparam int unsigned NUM_TAPS   = 4;

   // lag, in rounds, of each recurrence tap; the largest equals the window depth
   function automatic int unsigned tap_lag(input int unsigned idx);
      case (idx)
         0:       tap_lag = 16;
         1:       tap_lag = 14;
         2:       tap_lag = 8;
         default: tap_lag = 3;
      endcase
   endfunction

endpackage

// File: rtl/sha1_ws_seq.sv
`timescale 1ns/1ps
module sha1_ws_seq #(
   parameter int unsigned ROUNDS = sha1_ws_pkg::DEF_ROUNDS,
   parameter int unsigned WINDOW = sha1_ws_pkg::DEF_WINDOW,
   parameter int unsigned IDX_W  = $clog2(ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             enable,
   output logic [IDX_W-1:0] t_q,
   output logic             busy_q,
   output logic             pass,
   output logic             adv
);

   localparam logic [IDX_W-1:0] LAST_T = IDX_W'(ROUNDS - 1);
   localparam logic [IDX_W-1:0] PASS_T = IDX_W'(WINDOW);

   assign adv  = busy_q & enable;
   assign pass = (t_q < PASS_T);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_q    <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         t_q    <= '0;
         busy_q <= 1'b1;
      end else if (adv) begin
         if (t_q == LAST_T) begin
            t_q    <= '0;
            busy_q <= 1'b0;
         end else begin
            t_q <= t_q + 1'b1;
         end
      end
   end

   // R8: start always restarts at round zero
   a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy_q && t_q == '0));

   // R5: taking a word moves the index forward by one
   a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !start && t_q != LAST_T) |=> (busy_q && t_q == $past(t_q) + 1'b1));

   // R7: the last word ends the run
   a_r7_end_of_run: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !start && t_q == LAST_T) |=> !busy_q);

   // R7: idle persists without start
   a_r7_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start) |=> (!busy_q && t_q == '0));

   // R6: a stall freezes the index
   a_r6_stall_index: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !enable && !start) |=> (busy_q && $stable(t_q)));

endmodule

// File: rtl/sha1_ws_window.sv
`timescale 1ns/1ps
module sha1_ws_window #(
   parameter int unsigned WORD_W = sha1_ws_pkg::DEF_WORD_W,
   parameter int unsigned WINDOW = sha1_ws_pkg::DEF_WINDOW
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic                           shift,
   input  logic [WORD_W*WINDOW-1:0]       blk,
   input  logic [WORD_W-1:0]              fb,
   output logic [WINDOW-1:0][WORD_W-1:0]  win
);

   localparam int unsigned BLOCK_W = WORD_W * WINDOW;

   logic [WINDOW-1:0][WORD_W-1:0] win_q;

   // slot 0 holds the oldest word; slots move toward 0, new word enters at the top
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (load) begin
         for (int k = 0; k < int'(WINDOW); k++) begin
            win_q[k] <= blk[BLOCK_W-1-k*WORD_W -: WORD_W];
         end
      end else if (shift) begin
         for (int k = 0; k < int'(WINDOW) - 1; k++) begin
            win_q[k] <= win_q[k+1];
         end
         win_q[WINDOW-1] <= fb;
      end
   end

   assign win = win_q;

endmodule

// File: rtl/sha1_ws_mixer.sv
`timescale 1ns/1ps
module sha1_ws_mixer #(
   parameter int unsigned WORD_W = sha1_ws_pkg::DEF_WORD_W,
   parameter int unsigned WINDOW = sha1_ws_pkg::DEF_WINDOW,
   parameter int unsigned ROT    = sha1_ws_pkg::DEF_ROT
) (
   input  logic [WINDOW-1:0][WORD_W-1:0] win,
   output logic [WORD_W-1:0]             mixed
);

   localparam int unsigned NT = sha1_ws_pkg::NUM_TAPS;

   logic [WORD_W-1:0] acc [NT];

   for (genvar i = 0; i < int'(NT); i++) begin : g_tap
      localparam int unsigned POS = WINDOW - sha1_ws_pkg::tap_lag(i);
      if (i == 0) begin : g_first
         assign acc[i] = win[POS];
      end else begin : g_chain
         assign acc[i] = acc[i-1] ^ win[POS];
      end
   end

   assign mixed = {acc[NT-1][WORD_W-1-ROT:0], acc[NT-1][WORD_W-1 -: ROT]};

endmodule

// File: rtl/sha1_wsched.sv
`timescale 1ns/1ps
module sha1_wsched #(
   parameter int unsigned WORD_W = sha1_ws_pkg::DEF_WORD_W,
   parameter int unsigned WINDOW = sha1_ws_pkg::DEF_WINDOW,
   parameter int unsigned ROUNDS = sha1_ws_pkg::DEF_ROUNDS,
   parameter int unsigned ROT    = sha1_ws_pkg::DEF_ROT
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        enable,
   input  logic [WORD_W*WINDOW-1:0]    block_in,
   output logic [WORD_W-1:0]           wt_word,
   output logic [$clog2(ROUNDS)-1:0]   wt_idx,
   output logic                        wt_valid
);

   localparam int unsigned IDX_W = $clog2(ROUNDS);

   initial begin : elab_checks
      assert (WINDOW == sha1_ws_pkg::tap_lag(0))
         else $error("window depth must equal the largest recurrence lag");
      assert (ROUNDS > WINDOW) else $error("round count must exceed window depth");
      assert (ROT >= 1 && ROT < WORD_W) else $error("rotate amount out of range");
   end

   logic [IDX_W-1:0]              t_q;
   logic                          busy_q, pass, adv, shift;
   logic [WINDOW-1:0][WORD_W-1:0] win;
   logic [WORD_W-1:0]             mixed, fb;

   sha1_ws_seq #(.ROUNDS(ROUNDS), .WINDOW(WINDOW), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
      .t_q(t_q), .busy_q(busy_q), .pass(pass), .adv(adv)
   );

   assign shift = adv & ~start;

   // feedback select: recirculate message words first, then close the recurrence
   assign fb = pass ? win[0] : mixed;

   sha1_ws_window #(.WORD_W(WORD_W), .WINDOW(WINDOW)) u_win (
      .clk(clk), .rst_n(rst_n), .load(start), .shift(shift),
      .blk(block_in), .fb(fb), .win(win)
   );

   sha1_ws_mixer #(.WORD_W(WORD_W), .WINDOW(WINDOW), .ROT(ROT)) u_mix (
      .win(win), .mixed(mixed)
   );

   // output select: message word straight through, or the freshly computed word
   assign wt_word  = pass ? win[0] : mixed;
   assign wt_idx   = t_q;
   assign wt_valid = adv;

   // R6: the pending word does not change during a stall
   a_r6_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !enable && !start) |=> $stable(wt_word));

   // R5: no index beyond the last round is ever offered
   a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wt_valid |-> (int'(wt_idx) < int'(ROUNDS)));

   // R1: nothing is offered before the first start
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> !wt_valid);

endmodule

// File: tb/sim_sha1_wsched.sv
`timescale 1ns/1ps
module sim_sha1_wsched;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         enable = 1'b0;
   logic [511:0] block_in = '0;
   logic [31:0]  wt_word;
   logic [6:0]   wt_idx;
   logic         wt_valid;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   sha1_wsched u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
      .block_in(block_in), .wt_word(wt_word), .wt_idx(wt_idx), .wt_valid(wt_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rol1(input logic [31:0] x);
      return {x[30:0], x[31]};
   endfunction

   function automatic logic [31:0] model_word(input logic [511:0] blk, input int t);
      logic [31:0] w [80];
      for (int k = 0; k < 16; k++) w[k] = blk[511-32*k -: 32];
      for (int k = 16; k < 80; k++) w[k] = rol1(w[k-3] ^ w[k-8] ^ w[k-14] ^ w[k-16]);
      return w[t];
   endfunction

   function automatic logic [511:0] rand_block();
      logic [511:0] b;
      for (int k = 0; k < 16; k++) b[32*k +: 32] = $urandom;
      return b;
   endfunction

   // entered and left at a falling edge
   task automatic run_block(input logic [511:0] blk, input int en_pct,
                            input int stop_at, input bit start_en, input string tag0);
      block_in = blk;
      start    = 1'b1;
      enable   = start_en;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < stop_at; t++) begin
         bit taken = 0;
         bit first = (t == 0) && !start_en;
         while (!taken) begin
            bit en = first ? 1'b0 : ($urandom_range(99) < en_pct);
            first  = 0;
            enable = en;
            #1;
            if (t == 0) begin
               chk({tag0, " idx at round 0"}, 32'(wt_idx), 32'd0);
               chk({tag0, " word 0"}, wt_word, model_word(blk, 0));
            end else begin
               chk(t < 16 ? "R3 message word" : "R4 recurrence word",
                   wt_word, model_word(blk, t));
               chk("R5 idx order", 32'(wt_idx), 32'(t));
            end
            chk(en ? "R5 valid when enabled" : "R6 valid low in stall",
                32'(wt_valid), 32'(en));
            taken = en;
            @(posedge clk); @(negedge clk);
         end
      end
   endtask

   task automatic check_idle(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         enable = 1'b1;
         #1;
         chk("R7 valid low after round 79", 32'(wt_valid), 32'd0);
         chk("R7 idx back to 0", 32'(wt_idx), 32'd0);
         @(posedge clk); @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      @(negedge clk);
      #1;
      chk("R1 valid in reset", 32'(wt_valid), 32'd0);
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      enable = 1'b1;
      #1;
      chk("R1 valid after reset", 32'(wt_valid), 32'd0);
      chk("R1 idx after reset", 32'(wt_idx), 32'd0);
      @(posedge clk); @(negedge clk);
      #1;
      chk("R7 enable alone does not start", 32'(wt_valid), 32'd0);
      @(negedge clk);

      // directed corner blocks, no stalls
      run_block('0, 100, 80, 1'b1, "R2");
      check_idle(3);
      run_block({512{1'b1}}, 100, 80, 1'b1, "R2");
      check_idle(2);
      run_block({1'b1, 511'b0}, 100, 80, 1'b1, "R2");
      run_block({480'b0, 32'h0000_0001}, 100, 80, 1'b1, "R2");
      begin
         logic [511:0] ramp;
         for (int k = 0; k < 16; k++) ramp[511-32*k -: 32] = 32'h0101_0101 * (k + 1);
         run_block(ramp, 100, 80, 1'b1, "R2");
      end
      check_idle(2);

      // start with enable low
      run_block(rand_block(), 60, 80, 1'b0, "R9");
      check_idle(2);

      // restart in the middle of a run
      run_block(rand_block(), 80, 30, 1'b1, "R2");
      run_block(rand_block(), 80, 80, 1'b1, "R8");
      run_block(rand_block(), 100, 5, 1'b1, "R2");
      run_block(rand_block(), 50, 80, 1'b1, "R8");
      check_idle(2);

      // random blocks with random stalls
      for (int b = 0; b < 8; b++) begin
         run_block(rand_block(), 40 + 8 * b, 80, 1'b1, "R2");
      end
      check_idle(3);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule